// File: doc/BRIEF.md
# GPIO Pin Event Unit

The unit watches 32 general-purpose input pins and turns their activity into interrupt requests. Each pin is configured on its own to react either to a level or to an edge. In level mode, software picks whether high or low is the active level. In edge mode, software picks which edge directions count and whether an event stays latched until software clears it or is only visible for the cycle in which it is seen. A per-pin pending bit and a per-pin enable bit combine into one interrupt line for the processor.

Software reaches the unit over a simple 16-bit register bus with a byte offset, a write strobe and combinational read data. Every per-pin control lives in a pair of 16-bit registers. The lower register of a pair covers pins 0 to 15 and the upper one covers pins 16 to 31. Input pins are asynchronous to the bus clock, so they are synchronised before any detection takes place.

Top module: `pin_event_unit`

## Requirements
- R1: A pin value sampled at clock edge n first affects the pending bits at edge n+2 and the interrupt output at edge n+3. Pins pass through two synchronising flops before detection.
- R2: With mode bit 0 (level), a pin's pending bit is recomputed on every clock. It is 1 when the synchronised input equals the pin's polarity bit (1 means high is active, 0 means low is active). Writing 1 to it has no lasting effect while the level stays active.
- R3: With mode bit 1 and latch bit 1, a detected edge sets the pending bit, and the bit stays set until software writes 1 to it. If an edge is detected in the same cycle as that write, the bit stays set.
- R4: With mode bit 1 and latch bit 0, the pending bit is 1 for exactly the one cycle after each detected edge, and is 0 otherwise.
- R5: In edge mode, a rise (0 to 1) counts only when the pin's rise-select bit is 1, and a fall (1 to 0) counts only when its fall-select bit is 1. With both bits set, both directions count. With neither bit set, no edge counts.
- R6: In latch mode, writing 0 to a pending bit leaves it unchanged.
- R7: `irq_o` is a registered OR over all pins of (pending AND enable). Enable bits do not change the pending bits that are read back.
- R8: Pin p below 16 maps to bit p of the lower register of a pair, and pin p of 16 or more maps to bit p-16 of the upper one. The byte offsets (lower/upper) are: pending 0x08/0x0A, enable 0x0C/0x0E, mode 0x10/0x12, polarity 0x14/0x16, latch 0x18/0x1A, fall-select 0x20/0x22, rise-select 0x24/0x26.
- R9: Writes to any other offset change nothing, and reads from any other offset return 0.
- R10: Reset clears every control register and every pending bit to 0. This leaves all pins in level mode with low as the active level and all interrupts masked, and `irq_o` is 0.
- R11: The enable, mode, polarity, latch, fall-select and rise-select registers read back the last value written to them, and they hold that value while no write targets them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and detection clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 32 | Asynchronous general-purpose input pins |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Embedded assertions check several properties on every cycle:
- the two-cycle synchroniser latency;
- that a latched pending bit is never dropped without a write-1 acknowledge;
- that pass-through pending bits appear only when the synchronised input changed;
- that edge pins with no edge selected never become pending;
- that configuration is untouched by writes to other offsets;
- that `irq_o` stays low after a cycle with all enables clear.

Only the bench scenarios can show the finer behaviour. This covers the exact polarity results in level mode, the collision of an edge with an acknowledge, the one-cycle pulse width in pass-through mode, the split between the lower and upper register halves at pins 15 and 16, and the read-back values. For these, a behavioural reference model is compared against the pending reads and `irq_o` on every clock.

// File: rtl/pe_pkg.sv
// Shared definitions for the pin event unit.
// Assumes a 16-bit data bus, 32 pins and 6-bit byte offsets.
package pe_pkg;

    localparam int ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND_LO = 6'h08, RA_PEND_HI = 6'h0A,
        RA_EN_LO   = 6'h0C, RA_EN_HI   = 6'h0E,
        RA_MODE_LO = 6'h10, RA_MODE_HI = 6'h12,
        RA_POL_LO  = 6'h14, RA_POL_HI  = 6'h16,
        RA_LAT_LO  = 6'h18, RA_LAT_HI  = 6'h1A,
        RA_FSEL_LO = 6'h20, RA_FSEL_HI = 6'h22,
        RA_RSEL_LO = 6'h24, RA_RSEL_HI = 6'h26
    } reg_addr_e;

    // True when the offset selects one of the defined registers.
    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        case (a)
            RA_PEND_LO, RA_PEND_HI, RA_EN_LO, RA_EN_HI,
            RA_MODE_LO, RA_MODE_HI, RA_POL_LO, RA_POL_HI,
            RA_LAT_LO, RA_LAT_HI, RA_FSEL_LO, RA_FSEL_HI,
            RA_RSEL_LO, RA_RSEL_HI: is_mapped = 1'b1;
            default: is_mapped = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pe_sync.sv
// Two-flop input synchroniser with one extra history stage.
// cur_o is the synchronised pin value and prev_o is its value one cycle earlier.
// Assumes the pins are asynchronous to clk. The reset is synchronous and active low.
module pe_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Resolve metastability, then keep one cycle of history for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

    // R1: the synchronised value is the pin value from two edges earlier
    a_r1_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (cur_o == $past(pin_i, 2)));

endmodule

// File: rtl/pe_detect.sv
// Per-pin pending-state logic. Each pin works in one of three ways:
// level following, latched edge, or pass-through edge.
// Assumes the inputs are already synchronised and the configuration comes from registers.
// In latch mode, a new edge takes priority over an acknowledge.
module pe_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] lat_i,
    input  logic [N-1:0] fsel_i,
    input  logic [N-1:0] rsel_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic pend_q;
        logic edge_hit;

        // Qualify a rise or a fall with the pin's direction selects.
        always_comb begin
            edge_hit = (rsel_i[i] &  cur_i[i] & ~prev_i[i]) |
                       (fsel_i[i] & ~cur_i[i] &  prev_i[i]);
        end

        // Update the pending bit according to the pin's mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
            end else if (!mode_i[i]) begin
                pend_q <= (cur_i[i] == pol_i[i]);
            end else if (lat_i[i]) begin
                pend_q <= edge_hit | (pend_q & ~ack_i[i]);
            end else begin
                pend_q <= edge_hit;
            end
        end

        assign pend_o[i] = pend_q;
    end

    // R3: a latched pending bit survives unless it was acknowledged
    a_r3_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_o & $past(mode_i & lat_i & pend_o & ~ack_i))
                   == $past(mode_i & lat_i & pend_o & ~ack_i)));

    // R4: a pass-through pin becomes pending only after its input changed
    a_r4_through_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_o & $past(mode_i & ~lat_i & ~(cur_i ^ prev_i))) == '0));

    // R5: an edge pin with no direction selected never becomes pending
    a_r5_no_select_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_o & $past(mode_i & ~rsel_i & ~fsel_i & ~pend_o)) == '0));

endmodule

// File: rtl/pe_regs.sv
// Register file for the pin event unit.
// Holds the per-pin enable, mode, polarity, latch and edge-select bits.
// It also turns writes to a pending register into acknowledge strobes
// and drives the combinational read-back.
// Assumes N equals twice the bus width. The reset is synchronous and active low.
module pe_regs
    import pe_pkg::*;
#(
    parameter int DW = 16,
    parameter int N  = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [N-1:0]      pend_i,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      mode_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      lat_o,
    output logic [N-1:0]      fsel_o,
    output logic [N-1:0]      rsel_o,
    output logic [N-1:0]      ack_o,
    output logic [DW-1:0]     rd_data
);

    localparam int LO_MSB = DW - 1;
    localparam int HI_LSB = DW;
    localparam int HI_MSB = N - 1;

    logic [N-1:0] en_q, mode_q, pol_q, lat_q, fsel_q, rsel_q;

    // Store configuration writes into the addressed half of each register pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            lat_q  <= '0;
            fsel_q <= '0;
            rsel_q <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_EN_LO:   en_q[LO_MSB:0]        <= wr_data;
                RA_EN_HI:   en_q[HI_MSB:HI_LSB]   <= wr_data;
                RA_MODE_LO: mode_q[LO_MSB:0]      <= wr_data;
                RA_MODE_HI: mode_q[HI_MSB:HI_LSB] <= wr_data;
                RA_POL_LO:  pol_q[LO_MSB:0]       <= wr_data;
                RA_POL_HI:  pol_q[HI_MSB:HI_LSB]  <= wr_data;
                RA_LAT_LO:  lat_q[LO_MSB:0]       <= wr_data;
                RA_LAT_HI:  lat_q[HI_MSB:HI_LSB]  <= wr_data;
                RA_FSEL_LO: fsel_q[LO_MSB:0]      <= wr_data;
                RA_FSEL_HI: fsel_q[HI_MSB:HI_LSB] <= wr_data;
                RA_RSEL_LO: rsel_q[LO_MSB:0]      <= wr_data;
                RA_RSEL_HI: rsel_q[HI_MSB:HI_LSB] <= wr_data;
                default: ;
            endcase
        end
    end

    // Turn a write to a pending register into per-pin write-1-to-clear strobes.
    always_comb begin
        ack_o = '0;
        if (wr_en) begin
            case (addr)
                RA_PEND_LO: ack_o[LO_MSB:0]      = wr_data;
                RA_PEND_HI: ack_o[HI_MSB:HI_LSB] = wr_data;
                default: ;
            endcase
        end
    end

    // Select the read-back half-word; undefined offsets read as zero.
    always_comb begin
        case (addr)
            RA_PEND_LO: rd_data = pend_i[LO_MSB:0];
            RA_PEND_HI: rd_data = pend_i[HI_MSB:HI_LSB];
            RA_EN_LO:   rd_data = en_q[LO_MSB:0];
            RA_EN_HI:   rd_data = en_q[HI_MSB:HI_LSB];
            RA_MODE_LO: rd_data = mode_q[LO_MSB:0];
            RA_MODE_HI: rd_data = mode_q[HI_MSB:HI_LSB];
            RA_POL_LO:  rd_data = pol_q[LO_MSB:0];
            RA_POL_HI:  rd_data = pol_q[HI_MSB:HI_LSB];
            RA_LAT_LO:  rd_data = lat_q[LO_MSB:0];
            RA_LAT_HI:  rd_data = lat_q[HI_MSB:HI_LSB];
            RA_FSEL_LO: rd_data = fsel_q[LO_MSB:0];
            RA_FSEL_HI: rd_data = fsel_q[HI_MSB:HI_LSB];
            RA_RSEL_LO: rd_data = rsel_q[LO_MSB:0];
            RA_RSEL_HI: rd_data = rsel_q[HI_MSB:HI_LSB];
            default:    rd_data = '0;
        endcase
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;
    assign lat_o  = lat_q;
    assign fsel_o = fsel_q;
    assign rsel_o = rsel_q;

    // R9: a write to an undefined offset leaves every control register as it was
    a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_mapped(addr)) |=> $stable({en_q, mode_q, pol_q, lat_q, fsel_q, rsel_q}));

    // R11: the control registers hold their value when no write occurs
    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({en_q, mode_q, pol_q, lat_q, fsel_q, rsel_q}));

endmodule

// File: rtl/pin_event_unit.sv
// Top level of the GPIO pin event unit.
// Synchronises the pins, detects level or edge events per pin, holds the
// control and pending registers on a 16-bit bus, and registers the
// combined interrupt request.
// Assumes a single clock and a synchronous active-low reset.
module pin_event_unit
    import pe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DW-1:0]     pin_i,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                irq_o
);

    localparam int N = 2 * DW;

    logic [N-1:0] cur, prev, pend, en, mode, pol, lat, fsel, rsel, ack;
    logic         irq_q;

    pe_sync #(.W(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    pe_detect #(.N(N)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (cur),
        .prev_i (prev),
        .mode_i (mode),
        .pol_i  (pol),
        .lat_i  (lat),
        .fsel_i (fsel),
        .rsel_i (rsel),
        .ack_i  (ack),
        .pend_o (pend)
    );

    pe_regs #(.DW(DW), .N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .addr    (bus_addr),
        .wr_data (bus_wdata),
        .pend_i  (pend),
        .en_o    (en),
        .mode_o  (mode),
        .pol_o   (pol),
        .lat_o   (lat),
        .fsel_o  (fsel),
        .rsel_o  (rsel),
        .ack_o   (ack),
        .rd_data (bus_rdata)
    );

    // Register the OR of all enabled pending pins as the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & en);
    end

    assign irq_o = irq_q;

    // R7: with every enable clear in the previous cycle, no request is raised
    a_r7_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) == '0) |-> !irq_o);

    // R7: a raised request always has an enabled pending pin behind it
    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(pend & en) != '0));

endmodule

// File: tb/tb_pin_event_unit.sv
`timescale 1ns/1ps
module tb_pin_event_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    always #10 clk = ~clk;

    pin_event_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R10";
    bit    armed  = 1'b0;
    bit    done   = 1'b0;

    // behavioural reference state
    bit [31:0] m_en, m_mode, m_pol, m_lat, m_fsel, m_rsel, m_pend;
    bit        m_irq;
    bit [31:0] hist[$];
    bit [31:0] cur_pins = '0;

    function automatic bit [15:0] half(bit [31:0] v, bit hi);
        return hi ? v[31:16] : v[15:0];
    endfunction

    function automatic bit [15:0] model_read(bit [5:0] a);
        case (a)
            6'h08: return half(m_pend, 0);  6'h0A: return half(m_pend, 1);
            6'h0C: return half(m_en, 0);    6'h0E: return half(m_en, 1);
            6'h10: return half(m_mode, 0);  6'h12: return half(m_mode, 1);
            6'h14: return half(m_pol, 0);   6'h16: return half(m_pol, 1);
            6'h18: return half(m_lat, 0);   6'h1A: return half(m_lat, 1);
            6'h20: return half(m_fsel, 0);  6'h22: return half(m_fsel, 1);
            6'h24: return half(m_rsel, 0);  6'h26: return half(m_rsel, 1);
            default: return 16'h0000;
        endcase
    endfunction

    function automatic bit [31:0] put_half(bit [31:0] v, bit hi, bit [15:0] d);
        if (hi) v[31:16] = d; else v[15:0] = d;
        return v;
    endfunction

    // advance the reference model across one rising edge
    task automatic model_edge(bit rst, bit [31:0] pins, bit we, bit [5:0] a, bit [15:0] d);
        bit [31:0] s, p, ack, nxt;
        bit        new_irq;
        if (!rst) begin
            m_en = 0; m_mode = 0; m_pol = 0; m_lat = 0; m_fsel = 0; m_rsel = 0;
            m_pend = 0; m_irq = 0;
            hist = '{32'h0, 32'h0, 32'h0};
            return;
        end
        s = hist[1];
        p = hist[2];
        new_irq = |(m_pend & m_en);
        ack = 0;
        if (we && a == 6'h08) ack[15:0]  = d;
        if (we && a == 6'h0A) ack[31:16] = d;
        for (int i = 0; i < 32; i++) begin
            bit ev;
            ev = (m_rsel[i] && s[i] && !p[i]) || (m_fsel[i] && !s[i] && p[i]);
            if (!m_mode[i])     nxt[i] = (s[i] == m_pol[i]);
            else if (m_lat[i])  nxt[i] = ev || (m_pend[i] && !ack[i]);
            else                nxt[i] = ev;
        end
        m_pend = nxt;
        if (we) begin
            case (a)
                6'h0C: m_en   = put_half(m_en, 0, d);   6'h0E: m_en   = put_half(m_en, 1, d);
                6'h10: m_mode = put_half(m_mode, 0, d); 6'h12: m_mode = put_half(m_mode, 1, d);
                6'h14: m_pol  = put_half(m_pol, 0, d);  6'h16: m_pol  = put_half(m_pol, 1, d);
                6'h18: m_lat  = put_half(m_lat, 0, d);  6'h1A: m_lat  = put_half(m_lat, 1, d);
                6'h20: m_fsel = put_half(m_fsel, 0, d); 6'h22: m_fsel = put_half(m_fsel, 1, d);
                6'h24: m_rsel = put_half(m_rsel, 0, d); 6'h26: m_rsel = put_half(m_rsel, 1, d);
                default: ;
            endcase
        end
        m_irq = new_irq;
        hist.push_front(pins);
        void'(hist.pop_back());
    endtask

    task automatic compare_now();
        bit [15:0] exp_rd;
        if (!armed) return;
        exp_rd = model_read(bus_addr);
        checks++;
        if (bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s rdata @%h actual=%h expected=%h", tag, bus_addr, bus_rdata, exp_rd);
        end
        checks++;
        if (irq_o !== m_irq) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, m_irq);
        end
    endtask

    // one clock: compare at the falling edge, drive new inputs, model the rising edge
    task automatic step(bit [31:0] pins, bit we, bit [5:0] a, bit [15:0] d);
        @(negedge clk);
        compare_now();
        pin_i = pins; bus_we = we; bus_addr = a; bus_wdata = d;
        cur_pins = pins;
        @(posedge clk);
        #1 model_edge(rst_n, pins, we, a, d);
    endtask

    task automatic wr(bit [5:0] a, bit [15:0] d);
        step(cur_pins, 1'b1, a, d);
    endtask

    task automatic rd(bit [5:0] a, int n);
        for (int k = 0; k < n; k++) step(cur_pins, 1'b0, a, 16'h0);
    endtask

    task automatic pins_to(bit [31:0] v, bit [5:0] a, int n);
        step(v, 1'b0, a, 16'h0);
        rd(a, n);
    endtask

    initial begin
        // R10: reset state
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        armed = 1'b1;
        rst_n = 1'b1;
        step(0, 0, 6'h08, 0);
        tag = "R10";
        for (int a = 8; a < 40; a += 2) rd(6'(a), 2);

        // R11: control registers read back what was written
        tag = "R11";
        wr(6'h10, 16'hA5C3); wr(6'h12, 16'h3C5A); rd(6'h10, 1); rd(6'h12, 1);
        wr(6'h14, 16'h1234); wr(6'h16, 16'h8765); rd(6'h14, 1); rd(6'h16, 1);
        wr(6'h18, 16'hFFFF); wr(6'h1A, 16'h00F0); rd(6'h18, 1); rd(6'h1A, 1);
        wr(6'h20, 16'h0F0F); wr(6'h22, 16'hF00F); rd(6'h20, 1); rd(6'h22, 1);
        wr(6'h24, 16'h5555); wr(6'h26, 16'hAAAA); rd(6'h24, 1); rd(6'h26, 1);
        wr(6'h0C, 16'h0001); wr(6'h0E, 16'h8000); rd(6'h0C, 2); rd(6'h0E, 2);
        for (int a = 12; a < 40; a += 2) if (a != 24'h1C && a != 30) wr(6'(a), 16'h0);
        wr(6'h1C, 16'h0); wr(6'h1E, 16'h0);
        rd(6'h08, 3);

        // R2: level mode with both polarities, ack has no lasting effect
        tag = "R2";
        wr(6'h14, 16'h0003);
        rd(6'h08, 3);
        pins_to(32'h0000_0001, 6'h08, 4);
        wr(6'h08, 16'h0001);
        rd(6'h08, 2);
        wr(6'h0C, 16'h0001);
        rd(6'h08, 4);
        pins_to(32'h0000_0000, 6'h08, 4);
        pins_to(32'h0000_0004, 6'h08, 3);

        // R1: latency of a single-cycle input pulse through to irq
        tag = "R1";
        wr(6'h0C, 16'h0002);
        step(32'h0000_0006, 0, 6'h08, 0);
        pins_to(32'h0000_0004, 6'h08, 5);
        wr(6'h0C, 16'h0000);

        // R8: split between low and high halves at pins 15 and 16
        tag = "R8";
        wr(6'h14, 16'h8000); wr(6'h16, 16'h0001);
        pins_to(32'h0001_0000, 6'h0A, 3);
        rd(6'h08, 2);
        pins_to(32'h0000_8000, 6'h08, 3);
        rd(6'h0A, 2);
        wr(6'h0E, 16'h0001);
        pins_to(32'h0001_0000, 6'h0A, 4);

        // R3: latched rising edge on pin 3 and pin 20, held until write-1
        tag = "R3";
        wr(6'h0E, 16'h0000);
        wr(6'h14, 16'hFFFF); wr(6'h16, 16'hFFFF);
        pins_to(32'h0000_0000, 6'h08, 3);
        wr(6'h18, 16'h0008); wr(6'h24, 16'h0008); wr(6'h10, 16'h0008);
        wr(6'h1A, 16'h0010); wr(6'h26, 16'h0010); wr(6'h12, 16'h0010);
        pins_to(32'h0010_0008, 6'h08, 4);
        rd(6'h0A, 2);
        pins_to(32'h0000_0000, 6'h08, 4);

        // R6: writing zeros leaves latched bits alone
        tag = "R6";
        wr(6'h08, 16'h0000); rd(6'h08, 2);
        wr(6'h0A, 16'hFFEF); rd(6'h0A, 2);
        tag = "R3";
        wr(6'h08, 16'h0008); rd(6'h08, 2);
        wr(6'h0A, 16'h0010); rd(6'h0A, 2);
        // edge arriving while the acknowledge is written
        step(32'h0000_0008, 0, 6'h08, 0);
        step(32'h0000_0008, 0, 6'h08, 0);
        step(32'h0000_0008, 1, 6'h08, 16'h0008);
        rd(6'h08, 3);
        wr(6'h08, 16'h0008); rd(6'h08, 2);

        // R5: direction selects on pins 20, 21, 22 (high half)
        tag = "R5";
        pins_to(32'h0000_0000, 6'h0A, 3);
        wr(6'h08, 16'hFFFF); wr(6'h0A, 16'hFFFF);
        wr(6'h12, 16'h0070); wr(6'h1A, 16'h0070);
        wr(6'h26, 16'h0020); wr(6'h22, 16'h0030);
        pins_to(32'h0070_0000, 6'h0A, 4);
        pins_to(32'h0000_0000, 6'h0A, 4);
        wr(6'h0A, 16'h0070); rd(6'h0A, 2);
        pins_to(32'h0040_0000, 6'h0A, 3);
        pins_to(32'h0000_0000, 6'h0A, 3);

        // R4: pass-through edges on pin 5 give one-cycle pulses
        tag = "R4";
        wr(6'h10, 16'h0028); wr(6'h24, 16'h0028); wr(6'h20, 16'h0020);
        pins_to(32'h0000_0020, 6'h08, 5);
        pins_to(32'h0000_0000, 6'h08, 5);
        step(32'h0000_0020, 0, 6'h08, 0);
        step(32'h0000_0000, 0, 6'h08, 0);
        step(32'h0000_0020, 0, 6'h08, 0);
        rd(6'h08, 5);

        // R7: enables gate irq without altering pending bits
        tag = "R7";
        wr(6'h0E, 16'h0010);
        pins_to(32'h0010_0020, 6'h0A, 4);
        wr(6'h0E, 16'h0000);
        rd(6'h0A, 3);
        wr(6'h0E, 16'h0010);
        rd(6'h0A, 2);
        wr(6'h0A, 16'h0010);
        rd(6'h0A, 3);

        // R9: undefined offsets ignore writes and read zero
        tag = "R9";
        wr(6'h00, 16'hFFFF); wr(6'h1C, 16'hFFFF); wr(6'h1E, 16'hFFFF);
        wr(6'h2A, 16'hFFFF); wr(6'h3E, 16'hFFFF);
        rd(6'h00, 1); rd(6'h1C, 1); rd(6'h2A, 1); rd(6'h3E, 1);
        for (int a = 12; a < 40; a += 2) rd(6'(a), 1);

        rd(6'h08, 2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog actual=timeout expected=completion", tag);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule